// File: doc/BRIEF.md
# Cascadable Latched Sink Driver

This block is the logic core of an eight-channel low-side output driver. A serial bit stream is clocked into an eight-stage shift chain. A separate latch clock copies the whole chain into a holding register. The holding register drives eight sink-enable outputs through a gate that an active-low enable controls. A 1 on an output means that channel pulls its load to ground, and a 0 means the channel is off. The analog switches, current limiting and clamping lie outside the block.

Several devices can be chained. A cascade output carries the last stage of the chain and changes on the falling edge of the shift clock. The next device samples it on the rising edge, so it gets half a shift period of extra hold margin. A single active-low clear empties the shift chain, the holding register and the cascade stage. The clear takes effect at once when it asserts. Its release is retimed separately into each clock domain.

Top module: `latched_sink_driver`

## Requirements
- R1: On every rising edge of `sclk`, the chain moves up one position and `ser_i` enters stage 0. Stage 7 is the oldest bit.
- R2: On every rising edge of `lclk`, the holding register takes a copy of all eight chain stages. Holding bit n comes from stage n.
- R3: While `clr_n` is low, the chain, the holding register and `cas_o` read zero. This takes effect without any clock edge.
- R4: While `oe_n` is high, `sink_o` is all zeros, whatever the holding register contains.
- R5: While `oe_n` is low, `sink_o[n]` equals holding bit n. A 1 means channel n sinks current.
- R6: `cas_o` shows chain stage 7. It changes only on the falling edge of `sclk`, so it keeps its old value between a rising edge and the following falling edge.
- R7: After `clr_n` rises, the first SYNC_STAGES rising edges of `sclk` are ignored, and so are the first SYNC_STAGES rising edges of `lclk`. The default is 2.
- R8: When `sclk` and `lclk` rise together, the holding register captures the chain contents from before that shift.
- R9: Two devices chained cascade to serial input, sharing both clocks, shift 16 bits correctly. After 16 shifts and one latch, the first bit sent appears on `sink_o[7]` of the second device.
- R10: The gate has no register in it. A change of `oe_n` reaches `sink_o` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock. The chain moves on the rising edge and the cascade stage updates on the falling edge. |
| lclk | input | 1 | Latch clock. The holding register loads on the rising edge. |
| clr_n | input | 1 | Active-low clear for every register. Asserts asynchronously and releases synchronously in each domain. |
| oe_n | input | 1 | Active-low output enable for the sink gate. |
| ser_i | input | 1 | Serial data input into stage 0. |
| sink_o | output | WIDTH | Sink-enable outputs. 1 means the channel is sinking current. |
| cas_o | output | 1 | Cascade serial output, carrying stage 7 retimed to the falling edge. |

## Verification
The hardest situations to reach are the ones where the two clock domains interact. These are a latch edge that lands on the same instant as a shift edge, and the edges swallowed just after a clear while the retimed releases have not yet arrived. The stimulus drives both clocks from tasks. A random mix of shift-only, latch-only and coincident pulses is interleaved with clears and enable toggles. A bench model tracks the pending ignored edges per domain. Directed sequences send data during the ignored edges and chain a second instance to push a marked bit through all sixteen stages.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
    parameter int unsigned LSD_WIDTH       = 8;
    parameter int unsigned LSD_SYNC_STAGES = 2;
endpackage

// File: rtl/lsd_rst_sync.sv
module lsd_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = 1'b1;
        end else begin : g_multi
            always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
        end
    endgenerate

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lsd_shift_chain.sv
module lsd_shift_chain #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_i,
    output logic [WIDTH-1:0] bits_o,
    output logic             cas_o
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_t;

    chain_t ch_d, ch_q;
    logic   cas_d, cas_q;

    always_comb begin
        ch_d      = ch_q;
        ch_d.bits = {ch_q.bits[WIDTH-2:0], ser_i};
        cas_d     = ch_q.bits[WIDTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    // retimed on the opposite edge for downstream hold margin
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cas_q <= 1'b0;
        else        cas_q <= cas_d;
    end

    assign bits_o = ch_q.bits;
    assign cas_o  = cas_q;
endmodule

// File: rtl/lsd_store_gate.sv
module lsd_store_gate #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_i,
    input  logic             oe_n,
    output logic [WIDTH-1:0] sink_o
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d      = hd_q;
        hd_d.bits = par_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_gate
            assign sink_o[b] = hd_q.bits[b] & ~oe_n;
        end
    endgenerate
endmodule

// File: rtl/latched_sink_driver.sv
module latched_sink_driver
    import lsd_pkg::*;
#(
    parameter int unsigned WIDTH       = LSD_WIDTH,
    parameter int unsigned SYNC_STAGES = LSD_SYNC_STAGES
) (
    input  logic             sclk,
    input  logic             lclk,
    input  logic             clr_n,
    input  logic             oe_n,
    input  logic             ser_i,
    output logic [WIDTH-1:0] sink_o,
    output logic             cas_o
);
    logic             sh_rst_n;
    logic             lt_rst_n;
    logic [WIDTH-1:0] sh_bits;

    lsd_rst_sync #(.STAGES(SYNC_STAGES)) u_sh_rst (
        .clk    (sclk),
        .arst_n (clr_n),
        .rst_n  (sh_rst_n)
    );

    lsd_rst_sync #(.STAGES(SYNC_STAGES)) u_lt_rst (
        .clk    (lclk),
        .arst_n (clr_n),
        .rst_n  (lt_rst_n)
    );

    lsd_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (sclk),
        .rst_n  (sh_rst_n),
        .ser_i  (ser_i),
        .bits_o (sh_bits),
        .cas_o  (cas_o)
    );

    lsd_store_gate #(.WIDTH(WIDTH)) u_store (
        .clk    (lclk),
        .rst_n  (lt_rst_n),
        .par_i  (sh_bits),
        .oe_n   (oe_n),
        .sink_o (sink_o)
    );
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic             sclk,
    input logic             lclk,
    input logic             clr_n,
    input logic             oe_n,
    input logic             ser_i,
    input logic             sh_rst_n,
    input logic             lt_rst_n,
    input logic [WIDTH-1:0] sh_bits,
    input logic [WIDTH-1:0] sink_o,
    input logic             cas_o
);
    // R1: chain moves one place per rising shift edge
    p_shift_move_r1: assert property (@(posedge sclk) disable iff (!sh_rst_n)
        sh_rst_n |=> sh_bits == {$past(sh_bits[WIDTH-2:0]), $past(ser_i)});

    // R2 and R8: holding register shows the chain sampled at the latch edge
    p_latch_copy_r2: assert property (@(posedge lclk) disable iff (!lt_rst_n)
        lt_rst_n |=> (oe_n || sink_o == $past(sh_bits)));

    // R3: everything is empty when the retimed release arrives
    p_clear_empty_r3: assert property (@(posedge sclk) disable iff (!clr_n)
        $rose(sh_rst_n) |-> (sh_bits == '0 && cas_o == 1'b0));

    // R4: disabled gate forces all channels off
    p_gate_off_r4: assert property (@(posedge lclk) disable iff (!lt_rst_n)
        oe_n |-> sink_o == '0);

    // R6: cascade stage matches the last stage at each rising shift edge
    p_cascade_r6: assert property (@(posedge sclk) disable iff (!sh_rst_n)
        sh_rst_n |-> cas_o == sh_bits[WIDTH-1]);
endmodule

bind latched_sink_driver lsd_checker #(.WIDTH(WIDTH)) u_chk (
    .sclk     (sclk),
    .lclk     (lclk),
    .clr_n    (clr_n),
    .oe_n     (oe_n),
    .ser_i    (ser_i),
    .sh_rst_n (sh_rst_n),
    .lt_rst_n (lt_rst_n),
    .sh_bits  (sh_bits),
    .sink_o   (sink_o),
    .cas_o    (cas_o)
);

// File: tb/tb_latched_sink_driver.sv
`timescale 1ns/1ps
module tb_latched_sink_driver;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic sclk = 1'b0, lclk = 1'b0, clr_n = 1'b0, oe_n = 1'b1, ser = 1'b0;
    logic [7:0] sink_a, sink_b;
    logic cas_a, cas_b;

    latched_sink_driver #(.WIDTH(8), .SYNC_STAGES(SYNC)) dut (
        .sclk(sclk), .lclk(lclk), .clr_n(clr_n), .oe_n(oe_n), .ser_i(ser),
        .sink_o(sink_a), .cas_o(cas_a));

    latched_sink_driver #(.WIDTH(8), .SYNC_STAGES(SYNC)) dut_b (
        .sclk(sclk), .lclk(lclk), .clr_n(clr_n), .oe_n(oe_n), .ser_i(cas_a),
        .sink_o(sink_b), .cas_o(cas_b));

    always #2 clk = ~clk;   // 250 MHz reference

    int n_vec = 0, n_err = 0, wd = 0;
    logic [7:0] ma = '0, mb = '0, la = '0, lb = '0;
    logic ca = 1'b0, cb = 1'b0;
    int sh_skip = SYNC, lt_skip = SYNC;

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    function automatic logic [7:0] gate(input logic [7:0] s, input logic en_n);
        return en_n ? 8'h00 : s;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_latch();
        if (lt_skip > 0) lt_skip--;
        else begin la = ma; lb = mb; end
    endtask

    task automatic model_shift(input logic d);
        if (sh_skip > 0) sh_skip--;
        else begin mb = {mb[6:0], ca}; ma = {ma[6:0], d}; end
    endtask

    // mode: 0 shift only, 1 shift with latch
    task automatic pulse(input logic d, input bit with_latch);
        logic old_ca;
        ser = d;
        #1;
        old_ca = ca;
        sclk = 1'b1;
        if (with_latch) begin lclk = 1'b1; model_latch(); end  // R8: pre-shift capture
        model_shift(d);
        #1;
        chk("R6 hold until fall", {7'b0, cas_a}, {7'b0, old_ca});
        sclk = 1'b0; lclk = 1'b0;
        ca = ma[7]; cb = mb[7];
        #1;
        chk("R6 cascade", {7'b0, cas_a}, {7'b0, ca});
        chk("R9 cascade b", {7'b0, cas_b}, {7'b0, cb});
        chk(with_latch ? "R8 both" : "R5 out a", sink_a, gate(la, oe_n));
        chk("R5 out b", sink_b, gate(lb, oe_n));
        #1;
    endtask

    task automatic latch_only();
        #1; lclk = 1'b1; model_latch();
        #1; lclk = 1'b0;
        #1;
        chk("R2 latch a", sink_a, gate(la, oe_n));
        chk("R2 latch b", sink_b, gate(lb, oe_n));
        #1;
    endtask

    task automatic set_oe(input logic v);
        oe_n = v;
        #1;
        chk(v ? "R4 gate off" : "R10 gate on", sink_a, gate(la, v));
        chk("R10 gate b", sink_b, gate(lb, v));
    endtask

    task automatic do_clear();
        clr_n = 1'b0;
        #1;
        ma = '0; mb = '0; la = '0; lb = '0; ca = 1'b0; cb = 1'b0;
        sh_skip = SYNC; lt_skip = SYNC;
        chk("R3 clear a", sink_a, 8'h00);
        chk("R3 clear cas", {6'b0, cas_b, cas_a}, 8'h00);
        chk("R3 clear b", sink_b, 8'h00);
        #1 clr_n = 1'b1;
        #1;
    endtask

    initial begin
        void'($urandom(32'h1D5E_ED01));
        #1;
        chk("R3 reset a", sink_a, 8'h00);
        chk("R3 reset cas", {7'b0, cas_a}, 8'h00);
        clr_n = 1'b1;
        #2;
        set_oe(1'b0);

        // R7: data sent during the swallowed edges is lost
        pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b1);
        latch_only();
        chk("R7 swallowed", sink_a, 8'h00);

        // R1: walk a single one through the chain
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) pulse(1'b0, 1'b0);
        latch_only();
        chk("R1 walk", sink_a, 8'h08);

        // R4 / R10: gate toggles without clocks
        set_oe(1'b1);
        chk("R4 off", sink_a, 8'h00);
        set_oe(1'b0);
        chk("R10 on", sink_a, 8'h08);

        // R8: coincident edge captures pre-shift contents
        pulse(1'b1, 1'b1);
        chk("R8 pre-shift", sink_a, 8'h08);

        // R9: 16-bit chain, marked first bit lands on b output 7
        do_clear();
        for (int i = 0; i < SYNC; i++) pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 15; i++) pulse(1'($urandom % 2), 1'b0);
        latch_only();
        chk("R9 first bit", {7'b0, sink_b[7]}, 8'h01);
        chk("R9 full b", sink_b, gate(lb, oe_n));

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom % 32);
            if (r < 16)      pulse(1'($urandom % 2), 1'b0);
            else if (r < 22) latch_only();
            else if (r < 27) pulse(1'($urandom % 2), 1'b1);
            else if (r < 31) set_oe(~oe_n);
            else             do_clear();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule